// File: doc/BRIEF.md
# Card Byte-Lane Steering Decoder

This block sits between a 16-bit removable-card host bus and an array of byte-wide memory segments grouped as even/odd pairs, plus one separate byte-wide attribute memory. On every rising clock edge it samples two active-low card enables, the low byte-select address bit, the pair-select address bits, a space-select line, the read and write enables, the write-protect switch and the host write data. From that sample it drives the per-segment chip selects and strobes, and it steers the data lanes for the following cycle.

The two enables choose one of four access shapes: standby, a byte access on the low lane, an odd-byte access on the high lane, or a full word. In a byte access on the low lane, an odd byte is transposed down onto the low lane. When the space-select line is low, the access goes to the attribute memory. In attribute space only the low lane and even addresses carry data. Any lane that is not driven, or that carries invalid attribute data, shows a fixed fill pattern. While the protect switch is active, every write strobe is held inactive.

Top module: `card_lane_steer`

## Requirements
- R1: After a cycle in which both card enables were high, no segment chip select and no attribute chip select is active, and neither host lane is driven (`host_lane_oe` = 2'b00).
- R2: Enable-1 low with enable-2 high selects byte access. Byte-select 0 selects the even segment of the pair, and byte-select 1 selects the odd segment. The selected segment's byte appears on the low lane (host bits 7:0), and the high lane stays undriven.
- R3: Enable-1 high with enable-2 low selects the odd segment of the pair only. Its byte appears on the high lane (host bits 15:8), and the low lane stays undriven.
- R4: Both enables low select word access. Byte-select is ignored, both segments of the pair are selected, the even byte appears on bits 7:0 and the odd byte on bits 15:8.
- R5: Segment 2p is the even segment and segment 2p+1 the odd segment of the pair p given by `pair_sel`. A byte access activates exactly one chip select, and a word access activates exactly two.
- R6: With the read enable high, no host lane is driven. A segment read strobe is low only when its chip select is active and the read enable was low.
- R7: Space-select low selects no segment. The attribute memory is selected in word access, or in byte access at byte-select 0. Its byte appears on the low lane, and the high lane is never driven in attribute space.
- R8: An attribute byte access at byte-select 1 leaves the attribute memory unselected. The low lane is still driven, but it carries the fill pattern instead of data.
- R9: A segment or attribute write strobe is low only when its chip select is active, the write enable was low and protection is off. Even and attribute write data take host bits 7:0. Odd write data takes host bits 7:0 in byte access and host bits 15:8 otherwise.
- R10: While the protect switch is sampled high, every segment and attribute write strobe stays high and `protect_status` is high.
- R11: All outputs reflect the inputs sampled at the previous rising edge. During synchronous reset everything is idle, `protect_status` is 0 and the write data outputs are 0.
- R12: Every undriven lane reads back as the fill pattern (default 8'hEE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_en1_n | input | 1 | Card enable 1, active low |
| card_en2_n | input | 1 | Card enable 2, active low |
| space_sel_n | input | 1 | Low selects attribute space |
| rd_en_n | input | 1 | Read enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| byte_sel | input | 1 | Address bit 0, odd/even byte |
| pair_sel | input | PAIR_W | Segment pair select (top address bits) |
| protect_sw | input | 1 | Write-protect switch, active high |
| host_wdata | input | 2*LANE_W | Host write data |
| host_rdata | output | 2*LANE_W | Host read data, fill pattern on undriven lanes |
| host_lane_oe | output | 2 | Lane drive enables, bit 0 = low lane |
| seg_cs_n | output | 2*PAIRS | Segment chip selects, active low |
| seg_oe_n | output | 2*PAIRS | Segment read strobes, active low |
| seg_we_n | output | 2*PAIRS | Segment write strobes, active low |
| seg_wdata_even | output | LANE_W | Write data to even segments |
| seg_wdata_odd | output | LANE_W | Write data to odd segments |
| seg_rdata | input | 2*PAIRS*LANE_W | Read data from all segments, segment i at bits i*LANE_W |
| attr_cs_n | output | 1 | Attribute memory chip select, active low |
| attr_oe_n | output | 1 | Attribute memory read strobe, active low |
| attr_we_n | output | 1 | Attribute memory write strobe, active low |
| attr_wdata | output | LANE_W | Attribute write data |
| attr_rdata | input | LANE_W | Attribute read data |
| protect_status | output | 1 | Registered write-protect status |

## Verification
The bench builds the block with its defaults: PAIRS = 4, LANE_W = 8 and a fill byte of 8'hEE. This brings all eight segment selects and all four pair decodes within reach, and lets every segment feed a distinct byte, so that a wrong pair, a wrong parity or a missing transposition shows up as a wrong value on a lane. Directed sweeps cover every enable combination in both spaces, at both byte-select values, and with protection on and off. A long pseudo-random run then mixes all inputs and compares every output against the reference model on each cycle.

// File: rtl/lane_steer_pkg.sv
// Shared types for the card byte-lane steering decoder.
// Assumes two active-low card enables define the access shape.
package lane_steer_pkg;

    // Access shape chosen by the two card enables.
    typedef enum logic [1:0] {
        AM_IDLE     = 2'b00,   // both enables high
        AM_LOW_BYTE = 2'b01,   // enable-1 only: byte on low lane
        AM_HIGH_ODD = 2'b10,   // enable-2 only: odd byte on high lane
        AM_WORD     = 2'b11    // both enables: full word
    } access_mode_t;

endpackage

// File: rtl/cardbus_mode_decode.sv
// Maps the two active-low card enables onto an access shape.
// Purely combinational; assumes enables are already synchronous to clk.
module cardbus_mode_decode
    import lane_steer_pkg::*;
(
    input  logic         en1_n,
    input  logic         en2_n,
    output access_mode_t mode
);

    // Shape selection from the enable pair.
    always_comb begin
        unique case ({en2_n, en1_n})
            2'b11:   mode = AM_IDLE;
            2'b10:   mode = AM_LOW_BYTE;
            2'b01:   mode = AM_HIGH_ODD;
            default: mode = AM_WORD;
        endcase
    end

endmodule

// File: rtl/segment_strobe_gen.sv
// Produces per-segment and attribute chip selects and read/write strobes.
// Assumes segment 2p is the even half and 2p+1 the odd half of pair p,
// and that all inputs come from the registered sample of the host bus.
module segment_strobe_gen
    import lane_steer_pkg::*;
#(
    parameter int PAIRS  = 4,
    parameter int PAIR_W = $clog2(PAIRS)
) (
    input  access_mode_t        mode,
    input  logic                attr_space,
    input  logic [PAIR_W-1:0]   pair,
    input  logic                odd_addr,
    input  logic                rd_req,
    input  logic                wr_req,
    input  logic                wr_block,
    output logic [2*PAIRS-1:0]  cs_n,
    output logic [2*PAIRS-1:0]  oe_n,
    output logic [2*PAIRS-1:0]  we_n,
    output logic                a_cs_n,
    output logic                a_oe_n,
    output logic                a_we_n
);

    logic even_hit;
    logic odd_hit;
    logic attr_hit;

    // Which half of the addressed pair this shape touches.
    always_comb begin
        even_hit = (mode == AM_WORD) || (mode == AM_LOW_BYTE && !odd_addr);
        odd_hit  = (mode == AM_WORD) || (mode == AM_HIGH_ODD) ||
                   (mode == AM_LOW_BYTE && odd_addr);
        attr_hit = attr_space && even_hit;
    end

    // One pair of segments per generate step.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic pair_on;
        assign pair_on = !attr_space && (pair == PAIR_W'(p));

        assign cs_n[2*p]   = !(pair_on && even_hit);
        assign cs_n[2*p+1] = !(pair_on && odd_hit);
        assign oe_n[2*p]   = cs_n[2*p]   || !rd_req;
        assign oe_n[2*p+1] = cs_n[2*p+1] || !rd_req;
        assign we_n[2*p]   = cs_n[2*p]   || !wr_req || wr_block;
        assign we_n[2*p+1] = cs_n[2*p+1] || !wr_req || wr_block;
    end

    // Attribute memory strobes: even bytes only.
    always_comb begin
        a_cs_n = !attr_hit;
        a_oe_n = !attr_hit || !rd_req;
        a_we_n = !attr_hit || !wr_req || wr_block;
    end

endmodule

// File: rtl/read_lane_mux.sv
// Steers segment or attribute bytes onto the two host lanes and
// raises a drive enable per lane. Undriven or invalid lanes carry FILL.
// Assumes segment read data is flattened, segment i at bits i*LANE_W.
module read_lane_mux
    import lane_steer_pkg::*;
#(
    parameter int               PAIRS  = 4,
    parameter int               LANE_W = 8,
    parameter logic [LANE_W-1:0] FILL  = 8'hEE,
    parameter int               PAIR_W = $clog2(PAIRS)
) (
    input  access_mode_t               mode,
    input  logic                       attr_space,
    input  logic [PAIR_W-1:0]          pair,
    input  logic                       odd_addr,
    input  logic                       rd_req,
    input  logic [2*PAIRS*LANE_W-1:0]  seg_rd,
    input  logic [LANE_W-1:0]          attr_rd,
    output logic [2*LANE_W-1:0]        lanes,
    output logic [1:0]                 lane_oe
);

    localparam int SEGS = 2 * PAIRS;

    logic [LANE_W-1:0] seg_byte [SEGS];

    // Unflatten the segment read bus.
    for (genvar s = 0; s < SEGS; s++) begin : g_unpack
        assign seg_byte[s] = seg_rd[s*LANE_W +: LANE_W];
    end

    // Lane selection per access shape and space.
    always_comb begin
        lanes   = {FILL, FILL};
        lane_oe = 2'b00;
        if (rd_req) begin
            if (attr_space) begin
                if (mode == AM_WORD) begin
                    lane_oe[0]          = 1'b1;
                    lanes[LANE_W-1:0]   = attr_rd;
                end else if (mode == AM_LOW_BYTE) begin
                    lane_oe[0]          = 1'b1;
                    lanes[LANE_W-1:0]   = odd_addr ? FILL : attr_rd;
                end
            end else begin
                unique case (mode)
                    AM_LOW_BYTE: begin
                        lane_oe[0]        = 1'b1;
                        lanes[LANE_W-1:0] = seg_byte[{pair, odd_addr}];
                    end
                    AM_HIGH_ODD: begin
                        lane_oe[1]               = 1'b1;
                        lanes[2*LANE_W-1:LANE_W] = seg_byte[{pair, 1'b1}];
                    end
                    AM_WORD: begin
                        lane_oe                  = 2'b11;
                        lanes[LANE_W-1:0]        = seg_byte[{pair, 1'b0}];
                        lanes[2*LANE_W-1:LANE_W] = seg_byte[{pair, 1'b1}];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/card_lane_steer.sv
// Top of the card byte-lane steering decoder. Samples the host bus on
// each rising edge, then decodes selects, strobes and lane steering from
// that sample. Assumes a synchronous host bus and synchronous active-low reset.
module card_lane_steer
    import lane_steer_pkg::*;
#(
    parameter int                PAIRS  = 4,
    parameter int                LANE_W = 8,
    parameter logic [LANE_W-1:0] FILL   = 8'hEE,
    parameter int                PAIR_W = $clog2(PAIRS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        card_en1_n,
    input  logic                        card_en2_n,
    input  logic                        space_sel_n,
    input  logic                        rd_en_n,
    input  logic                        wr_en_n,
    input  logic                        byte_sel,
    input  logic [PAIR_W-1:0]           pair_sel,
    input  logic                        protect_sw,
    input  logic [2*LANE_W-1:0]         host_wdata,
    output logic [2*LANE_W-1:0]         host_rdata,
    output logic [1:0]                  host_lane_oe,
    output logic [2*PAIRS-1:0]          seg_cs_n,
    output logic [2*PAIRS-1:0]          seg_oe_n,
    output logic [2*PAIRS-1:0]          seg_we_n,
    output logic [LANE_W-1:0]           seg_wdata_even,
    output logic [LANE_W-1:0]           seg_wdata_odd,
    input  logic [2*PAIRS*LANE_W-1:0]   seg_rdata,
    output logic                        attr_cs_n,
    output logic                        attr_oe_n,
    output logic                        attr_we_n,
    output logic [LANE_W-1:0]           attr_wdata,
    input  logic [LANE_W-1:0]           attr_rdata,
    output logic                        protect_status
);

    access_mode_t        mode_d;
    access_mode_t        mode_q;
    logic                attr_q;
    logic [PAIR_W-1:0]   pair_q;
    logic                odd_q;
    logic                rd_q;
    logic                wr_q;
    logic                wp_q;
    logic [LANE_W-1:0]   wd_even_q;
    logic [LANE_W-1:0]   wd_odd_q;

    cardbus_mode_decode u_mode (
        .en1_n (card_en1_n),
        .en2_n (card_en2_n),
        .mode  (mode_d)
    );

    // Sample the host bus once per cycle; reset parks it in standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= AM_IDLE;
            attr_q    <= 1'b0;
            pair_q    <= '0;
            odd_q     <= 1'b0;
            rd_q      <= 1'b0;
            wr_q      <= 1'b0;
            wp_q      <= 1'b0;
            wd_even_q <= '0;
            wd_odd_q  <= '0;
        end else begin
            mode_q    <= mode_d;
            attr_q    <= !space_sel_n;
            pair_q    <= pair_sel;
            odd_q     <= byte_sel;
            rd_q      <= !rd_en_n;
            wr_q      <= !wr_en_n;
            wp_q      <= protect_sw;
            wd_even_q <= host_wdata[LANE_W-1:0];
            wd_odd_q  <= (mode_d == AM_LOW_BYTE) ? host_wdata[LANE_W-1:0]
                                                 : host_wdata[2*LANE_W-1:LANE_W];
        end
    end

    segment_strobe_gen #(
        .PAIRS  (PAIRS),
        .PAIR_W (PAIR_W)
    ) u_strobe (
        .mode       (mode_q),
        .attr_space (attr_q),
        .pair       (pair_q),
        .odd_addr   (odd_q),
        .rd_req     (rd_q),
        .wr_req     (wr_q),
        .wr_block   (wp_q),
        .cs_n       (seg_cs_n),
        .oe_n       (seg_oe_n),
        .we_n       (seg_we_n),
        .a_cs_n     (attr_cs_n),
        .a_oe_n     (attr_oe_n),
        .a_we_n     (attr_we_n)
    );

    read_lane_mux #(
        .PAIRS  (PAIRS),
        .LANE_W (LANE_W),
        .FILL   (FILL),
        .PAIR_W (PAIR_W)
    ) u_mux (
        .mode       (mode_q),
        .attr_space (attr_q),
        .pair       (pair_q),
        .odd_addr   (odd_q),
        .rd_req     (rd_q),
        .seg_rd     (seg_rdata),
        .attr_rd    (attr_rdata),
        .lanes      (host_rdata),
        .lane_oe    (host_lane_oe)
    );

    // Write data and protect status straight from the sample.
    always_comb begin
        seg_wdata_even = wd_even_q;
        seg_wdata_odd  = wd_odd_q;
        attr_wdata     = wd_even_q;
        protect_status = wp_q;
    end

    // R1: standby input leaves every select off and every lane undriven.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(card_en1_n && card_en2_n))
        |-> (&seg_cs_n && attr_cs_n && host_lane_oe == 2'b00));

    // R5: byte access selects one segment, word access two.
    a_r5_byte_one_seg: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(space_sel_n && (card_en1_n != card_en2_n)))
        |-> ($countones(~seg_cs_n) == 1));
    a_r5_word_two_seg: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(space_sel_n && !card_en1_n && !card_en2_n))
        |-> ($countones(~seg_cs_n) == 2));

    // R6: read enable high keeps both lanes undriven.
    a_r6_no_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en_n)) |-> (host_lane_oe == 2'b00));

    // R7: attribute space never selects a segment nor the high lane.
    a_r7_attr_no_segment: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!space_sel_n)) |-> (&seg_cs_n && !host_lane_oe[1]));

    // R10: protect switch blocks every write strobe.
    a_r10_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(protect_sw))
        |-> (&seg_we_n && attr_we_n && protect_status));

    // R12: an undriven lane shows the fill pattern.
    a_r12_fill_low: assert property (@(posedge clk) disable iff (!rst_n)
        !host_lane_oe[0] |-> (host_rdata[LANE_W-1:0] == FILL));

endmodule

// File: tb/sim_card_lane_steer.sv
// Self-checking bench: behavioural reference model compared every cycle.
module sim_card_lane_steer;

    localparam int CLK_PERIOD = 10;
    localparam int PAIRS  = 4;
    localparam int LANE_W = 8;
    localparam int PAIR_W = 2;
    localparam logic [7:0] FILL = 8'hEE;
    localparam logic [7:0] ATTR_BYTE = 8'h5C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en1_n, en2_n, sp_n, rd_n, wr_n, bsel, wp;
    logic [1:0]  psel;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  lane_oe;
    logic [7:0]  cs_n, oe_n, we_n;
    logic [7:0]  wd_even, wd_odd, a_wd;
    logic [63:0] seg_rd;
    logic        a_cs_n, a_oe_n, a_we_n, wp_st;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Previously applied inputs (sampled by the DUT at the next posedge).
    logic        p_rst, p_en1, p_en2, p_sp, p_rd, p_wr, p_bs, p_wp;
    logic [1:0]  p_ps;
    logic [15:0] p_wd;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Each segment returns its own distinct byte.
    for (genvar s = 0; s < 8; s++) begin : g_seg
        assign seg_rd[s*8 +: 8] = 8'h30 + 8'(s * 17);
    end

    card_lane_steer #(.PAIRS(PAIRS), .LANE_W(LANE_W), .FILL(FILL)) u0 (
        .clk(clk), .rst_n(rst_n), .card_en1_n(en1_n), .card_en2_n(en2_n),
        .space_sel_n(sp_n), .rd_en_n(rd_n), .wr_en_n(wr_n), .byte_sel(bsel),
        .pair_sel(psel), .protect_sw(wp), .host_wdata(wdata),
        .host_rdata(rdata), .host_lane_oe(lane_oe), .seg_cs_n(cs_n),
        .seg_oe_n(oe_n), .seg_we_n(we_n), .seg_wdata_even(wd_even),
        .seg_wdata_odd(wd_odd), .seg_rdata(seg_rd), .attr_cs_n(a_cs_n),
        .attr_oe_n(a_oe_n), .attr_we_n(a_we_n), .attr_wdata(a_wd),
        .attr_rdata(ATTR_BYTE), .protect_status(wp_st)
    );

    function automatic logic [7:0] seg_val(int s);
        return 8'h30 + 8'(s * 17);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model of the previous sample, compared field by field.
    task automatic compare();
        logic [7:0]  e_cs, e_oe, e_we;
        logic [1:0]  e_loe;
        logic [15:0] e_rd;
        logic [7:0]  e_wde, e_wdo;
        logic        e_acs, e_aoe, e_awe, e_wps;
        string       tag;
        int          base;
        e_cs = 8'hFF; e_loe = 2'b00; e_rd = {FILL, FILL};
        e_acs = 1'b1; e_wde = 8'h00; e_wdo = 8'h00; e_wps = 1'b0;
        tag = "R11";
        if (p_rst) begin
            base = 2 * int'(p_ps);
            e_wps = p_wp;
            e_wde = p_wd[7:0];
            e_wdo = (!p_en1 && p_en2) ? p_wd[7:0] : p_wd[15:8];
            if (p_en1 && p_en2) tag = "R1";
            else if (!p_sp) begin
                tag = (!p_en1 && p_en2 && p_bs) ? "R8" : "R7";
                if (!p_en1 && (!p_en2 || !p_bs)) e_acs = 1'b0;
                if (!p_rd && !p_en1) begin
                    e_loe = 2'b01;
                    e_rd[7:0] = (p_en2 && p_bs) ? FILL : ATTR_BYTE;
                end
            end else if (!p_en1 && p_en2) begin
                tag = "R2";
                e_cs[base + int'(p_bs)] = 1'b0;
                if (!p_rd) begin e_loe = 2'b01; e_rd[7:0] = seg_val(base + int'(p_bs)); end
            end else if (p_en1 && !p_en2) begin
                tag = "R3";
                e_cs[base + 1] = 1'b0;
                if (!p_rd) begin e_loe = 2'b10; e_rd[15:8] = seg_val(base + 1); end
            end else begin
                tag = "R4";
                e_cs[base] = 1'b0; e_cs[base + 1] = 1'b0;
                if (!p_rd) begin
                    e_loe = 2'b11;
                    e_rd = {seg_val(base + 1), seg_val(base)};
                end
            end
        end
        e_oe  = (p_rst && !p_rd) ? e_cs : 8'hFF;
        e_we  = (p_rst && !p_wr && !p_wp) ? e_cs : 8'hFF;
        e_aoe = e_acs | !(p_rst && !p_rd);
        e_awe = e_acs | !(p_rst && !p_wr && !p_wp);
        chk(cs_n == e_cs, "R5", {tag, " seg_cs_n"}, 64'(cs_n), 64'(e_cs));
        chk(lane_oe == e_loe, "R6", {tag, " lane_oe"}, 64'(lane_oe), 64'(e_loe));
        chk(rdata == e_rd, "R12", {tag, " host_rdata"}, 64'(rdata), 64'(e_rd));
        chk(oe_n == e_oe, "R6", "seg_oe_n", 64'(oe_n), 64'(e_oe));
        chk(we_n == e_we, p_wp ? "R10" : "R9", "seg_we_n", 64'(we_n), 64'(e_we));
        chk({a_cs_n, a_oe_n, a_we_n} == {e_acs, e_aoe, e_awe}, "R7",
            "attr strobes", 64'({a_cs_n, a_oe_n, a_we_n}), 64'({e_acs, e_aoe, e_awe}));
        chk({wd_even, wd_odd, a_wd} == {e_wde, e_wdo, e_wde}, "R9",
            "write data", 64'({wd_even, wd_odd, a_wd}), 64'({e_wde, e_wdo, e_wde}));
        chk(wp_st == e_wps, "R10", "protect_status", 64'(wp_st), 64'(e_wps));
    endtask

    task automatic drive(input logic r, input logic e1, input logic e2,
                         input logic sp, input logic rd, input logic wr,
                         input logic bs, input logic [1:0] ps, input logic w,
                         input logic [15:0] d);
        rst_n = r; en1_n = e1; en2_n = e2; sp_n = sp; rd_n = rd; wr_n = wr;
        bsel = bs; psel = ps; wp = w; wdata = d;
        p_rst = r; p_en1 = e1; p_en2 = e2; p_sp = sp; p_rd = rd; p_wr = wr;
        p_bs = bs; p_ps = ps; p_wp = w; p_wd = d;
    endtask

    // One bench cycle: check the last sample, then apply the next.
    task automatic step(input logic r, input logic e1, input logic e2,
                        input logic sp, input logic rd, input logic wr,
                        input logic bs, input logic [1:0] ps, input logic w,
                        input logic [15:0] d);
        @(negedge clk);
        compare();
        drive(r, e1, e2, sp, rd, wr, bs, ps, w, d);
    endtask

    initial begin
        // R11: reset applied with busy-looking inputs must still read idle.
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 16'hA1B2);
        repeat (3) step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 16'hA1B2);
        // R1: standby.
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h1234);
        // R2..R5, R9: every shape, every pair, both byte-select values.
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 2; b++) begin
                step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'(b), 2'(p), 1'b0, 16'h0F00 + 16'(p*16 + b));
                step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'(b), 2'(p), 1'b0, 16'hC300 + 16'(p));
                step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'(b), 2'(p), 1'b0, 16'h7E81);
                step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'(b), 2'(p), 1'b0, 16'h5AA5);
                step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'(b), 2'(p), 1'b0, 16'h3CC3);
            end
        end
        // R6: read enable high.
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b0, 16'h0000);
        // R7, R8: attribute space in every shape.
        for (int b = 0; b < 2; b++) begin
            step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'(b), 2'd1, 1'b0, 16'h1111);
            step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'(b), 2'd1, 1'b0, 16'h2222);
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'(b), 2'd1, 1'b0, 16'h3333);
            step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'(b), 2'd2, 1'b0, 16'h4444);
        end
        // R10: protect switch during writes in both spaces.
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 16'h9999);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 16'h8888);
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 16'h7777);
        // Mixed pseudo-random traffic.
        for (int i = 0; i < 3000; i++) begin
            automatic logic [31:0] r = $urandom;
            step(r[31:28] != 4'h0, r[0], r[1], r[2] | r[3], r[4], r[5], r[6],
                 r[8:7], r[11:9] == 3'd0, r[27:12]);
        end
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule